// File: doc/BRIEF.md
# Nonvolatile Save/Restore Sequencer

This block controls a memory whose volatile array is shadowed by nonvolatile cells. It accepts three kinds of trigger. The first is a store or recall pulse from a software unlock detector. The second is a power-fail comparator flag, which reports that the supply has fallen below the switch threshold. The third is a power-good flag, which is low while the supply is below the reset threshold.

For each accepted request it runs a two-phase transfer timed by parameter cycle counts:

- A save erases the nonvolatile cells and then programs them from the array.
- A restore clears the array and then loads it from the nonvolatile cells.

While a transfer runs, or while the block is waiting on power events, it holds the external array port disabled.

A restore request is latched at reset and whenever power-good is low. That request runs by itself once power-good returns. With automatic save enabled, a power-fail flag starts a save with no software command. After that save the block stays blocked until power-good drops and comes back.

Top module: `nv_xfer_seq`

## Requirements
- R1: A save drives erase_o for exactly STORE_CYCLES/2 cycles and then program_o for exactly STORE_CYCLES/2 cycles, with no gap and never both at once.
- R2: A restore drives clear_o for exactly RECALL_CYCLES/2 cycles and then load_o for exactly RECALL_CYCLES/2 cycles, with no gap.
- R3: busy_o is high in the first cycle after the cycle in which a request is accepted. It stays high for exactly STORE_CYCLES or RECALL_CYCLES cycles and falls when the last phase ends.
- R4: port_en_o is low in every cycle that busy_o is high.
- R5: Reset, or power_good_i low, latches a restore request and holds port_en_o low. When power_good_i is high the restore starts by itself, and port_en_o returns high after it ends.
- R6: With auto_save_i high, power_fail_i high while idle with power present and no restore pending starts a save.
- R7: A restore never raises erase_o or program_o, so the nonvolatile contents are unchanged. Restores may be repeated.
- R8: Priority among new requests is: pending power-up restore, then power-fail save, then software save, then software restore.
- R9: Software or power-fail requests that arrive while busy_o is high are dropped. They never run later.
- R10: After a power-fail save the block stays blocked: no request is accepted and port_en_o is low. This lasts until power_good_i goes low and then high again, which runs a restore.
- R11: power_fail_i has no effect while auto_save_i is low. Software requests have no effect while power_good_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| power_good_i | input | 1 | Supply above the reset threshold |
| power_fail_i | input | 1 | Supply below the switch threshold |
| auto_save_i | input | 1 | Enables the automatic save on power fail |
| sw_store_i | input | 1 | One-cycle software save request |
| sw_recall_i | input | 1 | One-cycle software restore request |
| busy_o | output | 1 | Transfer in progress |
| port_en_o | output | 1 | External array access allowed |
| erase_o | output | 1 | Erase phase strobe |
| program_o | output | 1 | Program phase strobe |
| clear_o | output | 1 | Array clear phase strobe |
| load_o | output | 1 | Array load phase strobe |

## Verification
The bench counts the cycles of each phase strobe against a small array and nonvolatile model. A timer off by one would show a phase one cycle long or short. Wrong phase sequencing would leave the model holding stale or zero data.

Several cases are aimed at the request logic:

- A restore request injected during a save must never run. A queued request would show up as a second busy window.
- Power-fail and a software restore are raised in the same cycle, and only the save may run.
- After the automatic save, software requests must stay ignored until power-good cycles. A missing lock would start a new transfer.
- A power-fail flag with automatic save disabled must leave the block idle.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ERASE,
    PH_PROG,
    PH_CLEAR,
    PH_LOAD
  } phase_e;
endpackage

// File: rtl/nvs_phase_timer.sv
module nvs_phase_timer #(
  parameter int CW   = 4,
  parameter int MAXV = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == '0);

  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) <= MAXV);
endmodule

// File: rtl/nvs_req_arb.sv
module nvs_req_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_i,
  input  logic power_good_i,
  input  logic power_fail_i,
  input  logic auto_save_i,
  input  logic sw_store_i,
  input  logic sw_recall_i,
  output logic go_store_o,
  output logic go_recall_o,
  output logic blocked_o
);
  logic por_q, lock_q;
  logic ready, auto_go, por_go, sw_st, sw_rc;

  assign ready   = idle_i & power_good_i & ~lock_q;
  assign por_go  = ready & por_q;
  assign auto_go = ready & ~por_q & auto_save_i & power_fail_i;
  assign sw_st   = ready & ~por_q & ~auto_go & sw_store_i;
  assign sw_rc   = ready & ~por_q & ~auto_go & ~sw_store_i & sw_recall_i;

  assign go_store_o  = auto_go | sw_st;
  assign go_recall_o = por_go | sw_rc;
  assign blocked_o   = ~power_good_i | lock_q | por_q;

  // power-up restore request: latched while supply is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            por_q <= 1'b1;
    else if (!power_good_i) por_q <= 1'b1;
    else if (por_go)        por_q <= 1'b0;
  end

  // lock after automatic save until power cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            lock_q <= 1'b0;
    else if (!power_good_i) lock_q <= 1'b0;
    else if (auto_go)       lock_q <= 1'b1;
  end

  a_r8_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(go_store_o && go_recall_o));
  a_r5_por_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && power_good_i && por_q && !lock_q) |-> go_recall_o);
  a_r10_locked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_go && power_good_i) |=> (!go_store_o && !go_recall_o));
endmodule

// File: rtl/nv_xfer_seq.sv
module nv_xfer_seq #(
  parameter int STORE_CYCLES  = 16,
  parameter int RECALL_CYCLES = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic power_good_i,
  input  logic power_fail_i,
  input  logic auto_save_i,
  input  logic sw_store_i,
  input  logic sw_recall_i,
  output logic busy_o,
  output logic port_en_o,
  output logic erase_o,
  output logic program_o,
  output logic clear_o,
  output logic load_o
);
  import nvs_pkg::*;

  localparam int SPH   = (STORE_CYCLES / 2 > 0) ? STORE_CYCLES / 2 : 1;
  localparam int RPH   = (RECALL_CYCLES / 2 > 0) ? RECALL_CYCLES / 2 : 1;
  localparam int MAXPH = (SPH > RPH) ? SPH : RPH;
  localparam int CW    = $clog2(MAXPH + 1);
  localparam logic [CW-1:0] SLOAD = CW'(SPH - 1);
  localparam logic [CW-1:0] RLOAD = CW'(RPH - 1);

  phase_e        ph_q;
  logic          idle, go_store, go_recall, blocked, expire;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;

  assign idle = (ph_q == PH_IDLE);

  nvs_req_arb u_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .idle_i       (idle),
    .power_good_i (power_good_i),
    .power_fail_i (power_fail_i),
    .auto_save_i  (auto_save_i),
    .sw_store_i   (sw_store_i),
    .sw_recall_i  (sw_recall_i),
    .go_store_o   (go_store),
    .go_recall_o  (go_recall),
    .blocked_o    (blocked)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = SLOAD;
    unique case (ph_q)
      PH_IDLE: begin
        tmr_load = go_store | go_recall;
        tmr_val  = go_store ? SLOAD : RLOAD;
      end
      PH_ERASE: begin
        tmr_load = expire;
        tmr_val  = SLOAD;
      end
      PH_CLEAR: begin
        tmr_load = expire;
        tmr_val  = RLOAD;
      end
      default: ;
    endcase
  end

  nvs_phase_timer #(.CW(CW), .MAXV(MAXPH - 1)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expire_o   (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_IDLE;
    else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (go_store)       ph_q <= PH_ERASE;
          else if (go_recall) ph_q <= PH_CLEAR;
        end
        PH_ERASE: if (expire) ph_q <= PH_PROG;
        PH_PROG:  if (expire) ph_q <= PH_IDLE;
        PH_CLEAR: if (expire) ph_q <= PH_LOAD;
        PH_LOAD:  if (expire) ph_q <= PH_IDLE;
        default:  ph_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o    = ~idle;
  assign port_en_o = idle & ~blocked;
  assign erase_o   = (ph_q == PH_ERASE);
  assign program_o = (ph_q == PH_PROG);
  assign clear_o   = (ph_q == PH_CLEAR);
  assign load_o    = (ph_q == PH_LOAD);

  a_r1_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({erase_o, program_o, clear_o, load_o}));
  a_r1_prog_after_erase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(program_o) |-> $past(erase_o));
  a_r2_load_after_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(load_o) |-> $past(clear_o));
  a_r4_port_off_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !port_en_o);
  a_r3_busy_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && (go_store || go_recall)) |=> busy_o);
  a_r7_recall_no_nv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && go_recall) |=> (clear_o && !erase_o && !program_o));
endmodule

// File: tb/nv_xfer_seq_bench.sv
module nv_xfer_seq_bench;
  localparam int SC = 16;
  localparam int RC = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic power_good = 1'b0, power_fail = 1'b0, auto_save = 1'b0;
  logic sw_store = 1'b0, sw_recall = 1'b0;
  logic busy, port_en, erase, prog, clr, load;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] ram_m, nv_m;

  always #2 clk = ~clk;

  nv_xfer_seq #(.STORE_CYCLES(SC), .RECALL_CYCLES(RC)) u_nv_xfer_seq (
    .clk_i(clk), .rst_ni(rst_ni), .power_good_i(power_good),
    .power_fail_i(power_fail), .auto_save_i(auto_save),
    .sw_store_i(sw_store), .sw_recall_i(sw_recall),
    .busy_o(busy), .port_en_o(port_en), .erase_o(erase),
    .program_o(prog), .clear_o(clr), .load_o(load)
  );

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  // called at the first negedge after the request cycle
  task automatic run_op(input string r, input int e_er, input int e_pr,
                        input int e_cl, input int e_ld);
    int ner = 0, npr = 0, ncl = 0, nld = 0, nbusy = 0, npe = 0;
    bit bad_order = 1'b0;
    chk(busy === 1'b1, {r, " R3 busy rises next cycle"}, int'(busy), 1);
    for (int i = 0; i < 200 && busy === 1'b1; i++) begin
      nbusy++;
      if (port_en) npe++;
      if (erase) begin ner++; nv_m = 8'h00; if (npr > 0) bad_order = 1'b1; end
      if (prog)  begin npr++; nv_m = ram_m; end
      if (clr)   begin ncl++; ram_m = 8'h00; if (nld > 0) bad_order = 1'b1; end
      if (load)  begin nld++; ram_m = nv_m; end
      @(negedge clk);
    end
    chk(ner == e_er, {r, " R1 erase cycles"}, ner, e_er);
    chk(npr == e_pr, {r, " R1 program cycles"}, npr, e_pr);
    chk(ncl == e_cl, {r, " R2 clear cycles"}, ncl, e_cl);
    chk(nld == e_ld, {r, " R2 load cycles"}, nld, e_ld);
    chk(nbusy == e_er + e_pr + e_cl + e_ld, {r, " R3 busy length"}, nbusy,
        e_er + e_pr + e_cl + e_ld);
    chk(npe == 0, {r, " R4 port enabled while busy"}, npe, 0);
    chk(!bad_order, {r, " R1/R2 phase order"}, int'(bad_order), 0);
  endtask

  task automatic t_reset();
    chk(busy === 1'b0, "R3 reset busy", int'(busy), 0);
    chk(port_en === 1'b0, "R5 reset port disabled", int'(port_en), 0);
    chk({erase, prog, clr, load} === 4'b0, "R1 reset strobes", int'({erase, prog, clr, load}), 0);
  endtask

  task automatic t_power_up();
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R5 no restore while power low", int'(busy), 0);
    power_good = 1'b1;
    @(negedge clk);
    run_op("R5", 0, 0, RC/2, RC/2);
    chk(ram_m == 8'hC3, "R5 array loaded", ram_m, 8'hC3);
    @(negedge clk);
    chk(port_en === 1'b1, "R5 port enabled after restore", int'(port_en), 1);
  endtask

  task automatic t_sw_store();
    ram_m = 8'h5A;
    sw_store = 1'b1; @(negedge clk); sw_store = 1'b0;
    run_op("R1", SC/2, SC/2, 0, 0);
    chk(nv_m == 8'h5A, "R1 nv programmed", nv_m, 8'h5A);
  endtask

  task automatic t_sw_recall();
    for (int k = 0; k < 2; k++) begin
      ram_m = 8'h11;
      sw_recall = 1'b1; @(negedge clk); sw_recall = 1'b0;
      run_op("R7", 0, 0, RC/2, RC/2);
      chk(ram_m == 8'h5A, "R2 array restored", ram_m, 8'h5A);
      chk(nv_m == 8'h5A, "R7 nv unchanged", nv_m, 8'h5A);
      @(negedge clk);
    end
  endtask

  task automatic t_busy_drop();
    int nb = 0, ncl = 0;
    sw_store = 1'b1; @(negedge clk); sw_store = 1'b0;
    repeat (3) @(negedge clk);
    sw_recall = 1'b1; @(negedge clk); sw_recall = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (busy) nb++;
      if (clr) ncl++;
      @(negedge clk);
    end
    chk(nb == SC - 4, "R9 only the save ran", nb, SC - 4);
    chk(ncl == 0, "R9 dropped restore never ran", ncl, 0);
  endtask

  task automatic t_auto_priority();
    int nb = 0;
    ram_m = 8'h77;
    auto_save = 1'b1;
    power_fail = 1'b1; sw_recall = 1'b1;
    @(negedge clk); sw_recall = 1'b0;
    run_op("R6 R8", SC/2, SC/2, 0, 0);
    chk(nv_m == 8'h77, "R6 auto save content", nv_m, 8'h77);
    power_fail = 1'b0;
    @(negedge clk);
    chk(port_en === 1'b0, "R10 port blocked after auto save", int'(port_en), 0);
    sw_store = 1'b1; @(negedge clk); sw_store = 1'b0;
    sw_recall = 1'b1; @(negedge clk); sw_recall = 1'b0;
    for (int i = 0; i < 5; i++) begin
      if (busy) nb++;
      @(negedge clk);
    end
    chk(nb == 0, "R10 requests ignored while locked", nb, 0);
    power_good = 1'b0;
    repeat (2) @(negedge clk);
    ram_m = 8'hEE;
    power_good = 1'b1;
    @(negedge clk);
    run_op("R10", 0, 0, RC/2, RC/2);
    chk(ram_m == 8'h77, "R10 restore after power cycle", ram_m, 8'h77);
    @(negedge clk);
    chk(port_en === 1'b1, "R10 port enabled again", int'(port_en), 1);
  endtask

  task automatic t_ignored();
    int nb = 0;
    auto_save = 1'b0;
    power_fail = 1'b1;
    for (int i = 0; i < 5; i++) begin
      if (busy) nb++;
      @(negedge clk);
    end
    power_fail = 1'b0;
    chk(nb == 0, "R11 power fail ignored with auto save off", nb, 0);
    power_good = 1'b0;
    @(negedge clk);
    chk(port_en === 1'b0, "R11 port off with power low", int'(port_en), 0);
    nb = 0;
    sw_store = 1'b1; @(negedge clk); sw_store = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (busy) nb++;
      @(negedge clk);
    end
    chk(nb == 0, "R11 software save ignored with power low", nb, 0);
    power_good = 1'b1;
    @(negedge clk);
    run_op("R5", 0, 0, RC/2, RC/2);
  endtask

  initial begin
    nv_m = 8'hC3;
    ram_m = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_power_up();
    t_sw_store();
    t_sw_recall();
    t_busy_drop();
    t_auto_priority();
    t_ignored();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule